// File: doc/BRIEF.md
# Stored-Program Fetch-Decode-Execute Core

A small processor that runs binary programs out of a single word-addressed RAM, which holds both instructions and data. A control state machine steps through three phases for every instruction. It first reads the word at the instruction pointer and bumps the pointer. It then latches that word as the current instruction. Finally it carries out the instruction. There are sixteen 16-bit general registers, an 8-bit instruction pointer and one adder.

Three real instructions exist: a register add, a jump taken only when a named register holds a strictly positive signed value, and a load of a memory word into a register. A halt word parks the machine and raises `done`. Every other opcode does nothing. A test access port writes words into the RAM while the core is held in reset. A second port shows one chosen register, one cycle after it is selected.

Top module: `fde_core`

## Requirements
- R1: While `rst` is high at a clock edge, the instruction pointer and all sixteen registers become zero, `done` goes low and the core restarts at the fetch phase. Execution begins at address 0 on the first edge after `rst` falls.
- R2: Each instruction passes through fetch, then decode, then execute. Fetch advances the instruction pointer by one. ADD, JUMP, undefined and HALT words take 3 clock cycles each, and LOAD takes 4.
- R3: ADD (opcode bits [15:12] = 0001) writes reg[bits 11:8] + reg[bits 7:4] into reg[bits 3:0]. The sum wraps modulo 2^16.
- R4: JUMP (opcode 0010) loads the 8-bit target in bits [7:0] into the instruction pointer when reg[bits 11:8], read as two's complement, is greater than zero. This includes 0x7FFF.
- R5: JUMP with a register value of zero or a negative value (for example 0x8000 or 0xFFFF) leaves the instruction pointer alone, so the next sequential word runs.
- R6: LOAD (opcode 0011) copies the RAM word at address bits [7:0] into reg[bits 11:8]. It spends one extra execute cycle waiting for the RAM read.
- R7: Instructions and data share one RAM, so a LOAD that points at a program word returns that word's binary encoding.
- R8: Opcodes other than 0001, 0010, 0011 and 1111 change no register and do not redirect the instruction pointer.
- R9: HALT (opcode 1111) raises `done` and keeps it high. No word after the halt is executed until the next reset.
- R10: `obs_val` is a register output. One clock edge after `obs_sel` changes, it shows the register that `obs_sel` names.
- R11: A clock edge with `pre_we` high writes `pre_data` into RAM word `pre_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pre_we | input | 1 | RAM preload write enable |
| pre_addr | input | 8 | RAM preload word address |
| pre_data | input | 16 | RAM preload word |
| obs_sel | input | 4 | Register chosen for observation |
| obs_val | output | 16 | Contents of the chosen register, registered |
| done | output | 1 | High once a HALT has executed |

## Verification
Each scenario loads a short program and counts the clock edges from reset release to `done`. That count tells a correct phase sequence apart from one that skips or repeats a phase, and it also shows whether a jump was taken. The jump tests use the values 0x7FFF, 0, 0x8000 and 0xFFFF, which separate a signed test from an unsigned one or from a test against nonzero. The add test includes a sum that overflows, to check wraparound. A load of the program's own words shows that code and data share one RAM. Undefined opcodes are given operand fields that an ADD would act on, so a decode that wrongly acts on them shows up as a changed register.

// File: rtl/fde_pkg.sv
package fde_pkg;
  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_HALT   = 2'd3
  } phase_t;

  localparam int          OPC_W  = 4;
  localparam logic [3:0]  OP_ADD = 4'h1;
  localparam logic [3:0]  OP_JMP = 4'h2;
  localparam logic [3:0]  OP_LD  = 4'h3;
  localparam logic [3:0]  OP_HLT = 4'hF;
endpackage

// File: rtl/fde_mem.sv
module fde_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single write port, registered read port: block RAM shape
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fde_regs.sv
module fde_regs #(
  parameter int DATA_W = 16,
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RIDX_W-1:0] ra_idx,
  input  logic [RIDX_W-1:0] rb_idx,
  output logic [DATA_W-1:0] ra_val,
  output logic [DATA_W-1:0] rb_val,
  input  logic              we,
  input  logic [RIDX_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [RIDX_W-1:0] obs_idx,
  output logic [DATA_W-1:0] obs_val
);
  localparam int NREG = 1 << RIDX_W;

  logic [DATA_W-1:0] rf [NREG];

  assign ra_val = rf[ra_idx];
  assign rb_val = rf[rb_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      obs_val <= '0;
    end else begin
      if (we) rf[wa] <= wd;
      obs_val <= rf[obs_idx];
    end
  end

  // R3 / R6: a write lands in the addressed register
  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> rf[$past(wa)] == $past(wd));

  // R1: observation output leaves reset at zero
  a_r1_obs_cleared: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> obs_val == '0);
endmodule

// File: rtl/fde_ctrl.sv
module fde_ctrl
  import fde_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [RIDX_W-1:0] ra_idx,
  output logic [RIDX_W-1:0] rb_idx,
  input  logic [DATA_W-1:0] ra_val,
  input  logic [DATA_W-1:0] rb_val,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_wa,
  output logic [DATA_W-1:0] rf_wd,
  output logic              done
);
  localparam int OP_LSB = DATA_W - OPC_W;

  phase_t            phase;
  logic [ADDR_W-1:0] ip;
  logic [DATA_W-1:0] ir;
  logic              ld_wait;

  logic [OPC_W-1:0]  op;
  logic [RIDX_W-1:0] fld_d;
  logic [ADDR_W-1:0] fld_addr;
  logic [DATA_W-1:0] sum;
  logic              jump_go;
  logic              is_known;

  assign op       = ir[DATA_W-1 -: OPC_W];
  assign ra_idx   = ir[OP_LSB-1 -: RIDX_W];
  assign rb_idx   = ir[OP_LSB-1-RIDX_W -: RIDX_W];
  assign fld_d    = ir[RIDX_W-1:0];
  assign fld_addr = ir[ADDR_W-1:0];
  assign sum      = ra_val + rb_val;
  assign is_known = (op == OP_ADD) || (op == OP_JMP) || (op == OP_LD) || (op == OP_HLT);

  assign mem_raddr = (phase == ST_EXEC && op == OP_LD) ? fld_addr : ip;
  assign jump_go   = (phase == ST_EXEC) && (op == OP_JMP) &&
                     ($signed(ra_val) > $signed({DATA_W{1'b0}}));
  assign rf_we     = (phase == ST_EXEC) &&
                     ((op == OP_ADD) || (op == OP_LD && ld_wait));
  assign rf_wa     = (op == OP_ADD) ? fld_d : ra_idx;
  assign rf_wd     = (op == OP_ADD) ? sum : mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= ST_FETCH;
      ip      <= '0;
      ir      <= '0;
      ld_wait <= 1'b0;
      done    <= 1'b0;
    end else begin
      unique case (phase)
        ST_FETCH: begin
          ip    <= ip + 1'b1;
          phase <= ST_DECODE;
        end
        ST_DECODE: begin
          ir    <= mem_rdata;
          phase <= ST_EXEC;
        end
        ST_EXEC: begin
          case (op)
            OP_LD: begin
              if (!ld_wait) begin
                ld_wait <= 1'b1;
              end else begin
                ld_wait <= 1'b0;
                phase   <= ST_FETCH;
              end
            end
            OP_HLT: begin
              phase <= ST_HALT;
              done  <= 1'b1;
            end
            OP_JMP: begin
              if (jump_go) ip <= fld_addr;
              phase <= ST_FETCH;
            end
            default: phase <= ST_FETCH;
          endcase
        end
        ST_HALT: phase <= ST_HALT;
      endcase
    end
  end

  // R2: fetch steps the pointer by one and hands over to decode
  a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
    phase == ST_FETCH |=> phase == ST_DECODE && ip == ADDR_W'($past(ip) + 1'b1));

  // R2: decode always hands over to execute
  a_r2_decode_next: assert property (@(posedge clk) disable iff (rst)
    phase == ST_DECODE |=> phase == ST_EXEC);

  // R5: non-positive register never redirects the pointer
  a_r5_no_jump: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC && op == OP_JMP && !($signed(ra_val) > $signed({DATA_W{1'b0}})))
      |=> ip == $past(ip));

  // R6: a load stays in execute for a second cycle
  a_r6_load_wait: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC && op == OP_LD && !ld_wait) |=> phase == ST_EXEC);

  // R8: an undefined opcode returns to fetch without touching the pointer
  a_r8_nop: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC && !is_known) |=> phase == ST_FETCH && $stable(ip));

  // R9: halted machine stays parked with done high
  a_r9_halt_hold: assert property (@(posedge clk) disable iff (rst)
    phase == ST_HALT |=> phase == ST_HALT && done && $stable(ip));
endmodule

// File: rtl/fde_core.sv
module fde_core #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  input  logic [RIDX_W-1:0] obs_sel,
  output logic [DATA_W-1:0] obs_val,
  output logic              done
);
  logic [ADDR_W-1:0] mem_raddr;
  logic [DATA_W-1:0] mem_rdata;
  logic [RIDX_W-1:0] ra_idx, rb_idx, rf_wa;
  logic [DATA_W-1:0] ra_val, rb_val, rf_wd;
  logic              rf_we;

  fde_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mem (
    .clk   (clk),
    .we    (pre_we),
    .waddr (pre_addr),
    .wdata (pre_data),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  fde_regs #(.DATA_W(DATA_W), .RIDX_W(RIDX_W)) i_regs (
    .clk     (clk),
    .rst     (rst),
    .ra_idx  (ra_idx),
    .rb_idx  (rb_idx),
    .ra_val  (ra_val),
    .rb_val  (rb_val),
    .we      (rf_we),
    .wa      (rf_wa),
    .wd      (rf_wd),
    .obs_idx (obs_sel),
    .obs_val (obs_val)
  );

  fde_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RIDX_W(RIDX_W)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mem_rdata (mem_rdata),
    .mem_raddr (mem_raddr),
    .ra_idx    (ra_idx),
    .rb_idx    (rb_idx),
    .ra_val    (ra_val),
    .rb_val    (rb_val),
    .rf_we     (rf_we),
    .rf_wa     (rf_wa),
    .rf_wd     (rf_wd),
    .done      (done)
  );
endmodule

// File: tb/test_fde_core.sv
module test_fde_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pre_we = 1'b0;
  logic [7:0]  pre_addr = '0;
  logic [15:0] pre_data = '0;
  logic [3:0]  obs_sel = '0;
  logic [15:0] obs_val;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  fde_core i_fde_core (
    .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr),
    .pre_data(pre_data), .obs_sel(obs_sel), .obs_val(obs_val), .done(done)
  );

  function automatic logic [15:0] e_add(input int a, input int b, input int d);
    return {4'h1, 4'(a), 4'(b), 4'(d)};
  endfunction
  function automatic logic [15:0] e_jmp(input int r, input int t);
    return {4'h2, 4'(r), 8'(t)};
  endfunction
  function automatic logic [15:0] e_ld(input int r, input int a);
    return {4'h3, 4'(r), 8'(a)};
  endfunction
  localparam logic [15:0] HLT = 16'hF000;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic poke(input int a, input logic [15:0] d);
    pre_we = 1'b1; pre_addr = 8'(a); pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic run(output int cyc);
    rst = 1'b0;
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    if (cyc >= 1000) chk("watchdog run", 32'(cyc), 0);
  endtask

  task automatic rd(input int i, output logic [15:0] v);
    obs_sel = 4'(i);
    @(posedge clk);
    @(negedge clk);
    v = obs_val;
  endtask

  task automatic t_add();
    int c; logic [15:0] v;
    hold_reset();
    poke(0, e_ld(1, 8'h80)); poke(1, e_ld(2, 8'h81));
    poke(2, e_add(1, 2, 3)); poke(3, e_add(3, 3, 3));
    poke(4, e_ld(4, 8'h82)); poke(5, e_add(4, 1, 5)); poke(6, HLT);
    poke(8'h80, 16'd5); poke(8'h81, 16'd7); poke(8'h82, 16'hFFFF);
    run(c);
    chk("R2 cycle count loads+adds", 32'(c), 24);
    rd(1, v); chk("R11 preloaded word via load", v, 16'd5);
    rd(3, v); chk("R3 add chain", v, 16'd24);
    rd(5, v); chk("R3 add wraps", v, 16'd4);
    rd(4, v); chk("R6 load value", v, 16'hFFFF);
  endtask

  task automatic t_reset();
    int c; logic [15:0] v;
    hold_reset();
    chk("R1 done low in reset", 32'(done), 0);
    poke(0, HLT);
    run(c);
    chk("R2 halt alone takes 3 cycles", 32'(c), 3);
    for (int i = 0; i < 16; i++) begin
      rd(i, v); chk($sformatf("R1 reg %0d cleared", i), v, 16'd0);
    end
  endtask

  task automatic t_jump_taken();
    int c; logic [15:0] v;
    hold_reset();
    poke(0, e_ld(1, 8'h83)); poke(1, e_jmp(1, 5)); poke(2, e_ld(2, 8'h84));
    poke(3, HLT); poke(4, HLT); poke(5, e_ld(3, 8'h85)); poke(6, HLT);
    poke(8'h83, 16'h7FFF); poke(8'h84, 16'h0BAD); poke(8'h85, 16'h0077);
    run(c);
    chk("R4 taken path cycle count", 32'(c), 14);
    rd(2, v); chk("R4 skipped word not run", v, 16'd0);
    rd(3, v); chk("R4 target word run", v, 16'h0077);
  endtask

  task automatic t_jump_not();
    int c; logic [15:0] v;
    hold_reset();
    poke(0, e_ld(2, 8'h86)); poke(1, e_ld(3, 8'h87));
    poke(2, e_jmp(1, 8'h20)); poke(3, e_jmp(2, 8'h20)); poke(4, e_jmp(3, 8'h20));
    poke(5, e_ld(4, 8'h88)); poke(6, HLT);
    poke(8'h20, e_ld(5, 8'h89)); poke(8'h21, HLT);
    poke(8'h86, 16'h8000); poke(8'h87, 16'hFFFF);
    poke(8'h88, 16'h0055); poke(8'h89, 16'h0099);
    run(c);
    chk("R5 fallthrough cycle count", 32'(c), 24);
    rd(4, v); chk("R5 sequential word run", v, 16'h0055);
    rd(5, v); chk("R5 target never reached", v, 16'd0);
  endtask

  task automatic t_shared();
    int c; logic [15:0] v;
    hold_reset();
    poke(0, e_ld(1, 0)); poke(1, e_ld(2, 1)); poke(2, HLT);
    run(c);
    chk("R6 two loads cycle count", 32'(c), 11);
    rd(1, v); chk("R7 load own code word", v, 16'h3100);
    rd(2, v); chk("R7 load next code word", v, 16'h3201);
  endtask

  task automatic t_nop();
    int c; logic [15:0] v;
    hold_reset();
    poke(0, e_ld(1, 8'h80)); poke(1, e_ld(2, 8'h81));
    poke(2, 16'h0123); poke(3, 16'h4123); poke(4, 16'hE123); poke(5, HLT);
    poke(8'h80, 16'd5); poke(8'h81, 16'd7);
    run(c);
    chk("R8 undefined words take 3 cycles", 32'(c), 20);
    rd(3, v); chk("R8 no register written", v, 16'd0);
    rd(1, v); chk("R8 source kept", v, 16'd5);
  endtask

  task automatic t_halt_obs();
    int c; logic [15:0] v;
    hold_reset();
    poke(0, e_ld(1, 8'h80)); poke(1, e_ld(2, 8'h81)); poke(2, HLT); poke(3, e_add(1, 1, 1));
    run(c);
    repeat (20) @(negedge clk);
    chk("R9 done stays high", 32'(done), 1);
    rd(1, v); chk("R9 word after halt not run", v, 16'd5);
    obs_sel = 4'd2;
    #1;
    chk("R10 output not yet switched", obs_val, 16'd5);
    @(posedge clk); @(negedge clk);
    chk("R10 output after one edge", obs_val, 16'd7);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_add();
    t_reset();
    t_jump_taken();
    t_jump_not();
    t_shared();
    t_nop();
    t_halt_obs();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule